// File: doc/BRIEF.md
# Renaming Issue Stage with Reservation Stations

This block is the issue and operand-gathering stage of a small out-of-order arithmetic core. Instructions arrive one per cycle in program order over a valid/ready handshake. Each accepted instruction takes a free reservation station. Each of its two source registers is resolved at that moment. A source with no pending writer is read from the register file. A pending source is replaced by the station number that will produce it, and that number serves as the rename tag. Source and destination fields are register indices.

Stations watch a single result bus and capture any operand whose tag is broadcast. A station that holds both operands asks for dispatch to a pipelined functional-unit stub with fixed latency. The stub's result comes back on the bus, which frees the station. A status table keeps a valid bit and a producer tag for each register. Only the newest producer of a register may write it. This removes write-after-read and write-after-write hazards, and read-after-write order is kept by tag matching.

Top module: `fpr_rename_core`

## Requirements
- R1: After reset, register i holds the value i+1, no register is pending, `in_ready` is 1 and `cdb_valid` is 0.
- R2: `in_ready` is 1 exactly when at least one station is free. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Otherwise it is held and not lost. An accepted instruction takes the lowest-numbered free station.
- R3: The result written to the destination follows the 2-bit `in_op` code on 16-bit values modulo 2^DW: 0 = a+b, 1 = a-b, 2 = a AND b, 3 = a XOR b. The final register contents equal those of executing the accepted stream one instruction at a time in program order.
- R4: A source whose producer broadcasts in the same cycle the consumer is accepted takes the broadcast value, not the stale register value.
- R5: A broadcast writes a register only when that register's status entry is valid and holds the broadcast tag. The entry then clears, unless a new writer of that register is accepted in the same cycle. Only the last-issued writer of a register updates it.
- R6: Among stations that are ready in the same cycle, the lowest-numbered one is dispatched, at most one per cycle. Its result is broadcast LAT cycles after the dispatch cycle, tagged with its station number.
- R7: A station is freed on the clock edge that ends its broadcast cycle, so it can be allocated again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | A station is free; the instruction is taken on this edge |
| in_op | input | 2 | Operation code (see R3) |
| in_dst | input | $clog2(NREG) | Destination register index |
| in_src_a | input | $clog2(NREG) | First source register index |
| in_src_b | input | $clog2(NREG) | Second source register index |
| reg_value | output | NREG*DW | Register file contents, register i at bits [i*DW +: DW] |
| reg_pending | output | NREG | Bit i set while register i awaits a producer |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | $clog2(NRS) | Station number of the broadcast result |
| cdb_value | output | DW | Broadcast result value |

## Verification
The bench builds the block with 4 registers, 6 stations, 16-bit data and a latency of 3. With only four destinations, random streams overwrite the same register often while older writers are still in flight. This exercises tag replacement and makes a late-completing older writer meet a newer status entry. With six stations and a three-cycle unit, dependent chains fill every station, so stalls are reached routinely. A sweep of idle gaps between a producer and its consumer lands one consumer exactly on the producer's broadcast cycle. A directed pair of consumers that wake together shows the lowest-number dispatch order and the broadcast timing.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_AND = 2'd2,
      OP_XOR = 2'd3
   } fpr_op_e;

endpackage

// File: rtl/fpr_regstat.sv
module fpr_regstat #(
   parameter int NREG = 4,
   parameter int NRS  = 6,
   parameter int DW   = 16,
   localparam int RW  = $clog2(NREG),
   localparam int TW  = $clog2(NRS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 iss_fire,
   input  logic [RW-1:0]        iss_dst,
   input  logic [TW-1:0]        iss_tag,
   input  logic [RW-1:0]        src_a,
   input  logic [RW-1:0]        src_b,
   input  logic                 cdb_valid,
   input  logic [TW-1:0]        cdb_tag,
   input  logic [DW-1:0]        cdb_val,
   output logic                 a_rdy,
   output logic [DW-1:0]        a_val,
   output logic [TW-1:0]        a_tag,
   output logic                 b_rdy,
   output logic [DW-1:0]        b_val,
   output logic [TW-1:0]        b_tag,
   output logic [NREG*DW-1:0]   reg_flat,
   output logic [NREG-1:0]      pend
);

   logic [DW-1:0] rf    [NREG];
   logic [TW-1:0] ptag  [NREG];
   logic [NREG-1:0] pv;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic hit;
      assign hit = cdb_valid && pv[r] && (ptag[r] == cdb_tag);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rf[r]   <= DW'(r + 1);
            pv[r]   <= 1'b0;
            ptag[r] <= '0;
         end else begin
            if (hit) begin
               rf[r] <= cdb_val;
               pv[r] <= 1'b0;
            end
            if (iss_fire && iss_dst == RW'(r)) begin
               pv[r]   <= 1'b1;
               ptag[r] <= iss_tag;
            end
         end
      end

      assign reg_flat[r*DW +: DW] = rf[r];

      AST_LAST_WRITER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !(iss_fire && iss_dst == RW'(r))) |=> (!pv[r] && rf[r] == $past(cdb_val))); // R5
   end

   assign pend = pv;

   // resolve a source: pending producer, same-cycle broadcast, or register file
   function automatic logic [DW+TW:0] lookup(input logic [RW-1:0] s);
      logic [DW+TW:0] res;
      if (!pv[s])
         res = {1'b1, {TW{1'b0}}, rf[s]};
      else if (cdb_valid && ptag[s] == cdb_tag)
         res = {1'b1, ptag[s], cdb_val};
      else
         res = {1'b0, ptag[s], {DW{1'b0}}};
      return res;
   endfunction

   always_comb begin
      {a_rdy, a_tag, a_val} = lookup(src_a);
      {b_rdy, b_tag, b_val} = lookup(src_b);
   end

   AST_ISSUE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      iss_fire |=> (pv[$past(iss_dst)] && ptag[$past(iss_dst)] == $past(iss_tag))); // R5

endmodule

// File: rtl/fpr_station.sv
module fpr_station
   import fpr_pkg::*;
#(
   parameter int ID  = 0,
   parameter int NRS = 6,
   parameter int DW  = 16,
   localparam int TW = $clog2(NRS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           alloc,
   input  fpr_op_e        alloc_op,
   input  logic           a_rdy,
   input  logic [DW-1:0]  a_val,
   input  logic [TW-1:0]  a_tag,
   input  logic           b_rdy,
   input  logic [DW-1:0]  b_val,
   input  logic [TW-1:0]  b_tag,
   input  logic           cdb_valid,
   input  logic [TW-1:0]  cdb_tag,
   input  logic [DW-1:0]  cdb_val,
   input  logic           grant,
   output logic           busy,
   output logic           ready,
   output fpr_op_e        op,
   output logic [DW-1:0]  va,
   output logic [DW-1:0]  vb
);

   logic          sent;
   logic          ra, rb;
   logic [TW-1:0] qa, qb;
   logic          own_bcast;

   assign own_bcast = busy && cdb_valid && (cdb_tag == TW'(ID));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sent <= 1'b0;
         ra   <= 1'b0;
         rb   <= 1'b0;
         op   <= OP_ADD;
         qa   <= '0;
         qb   <= '0;
         va   <= '0;
         vb   <= '0;
      end else if (alloc) begin
         busy <= 1'b1;
         sent <= 1'b0;
         op   <= alloc_op;
         ra   <= a_rdy;
         va   <= a_val;
         qa   <= a_tag;
         rb   <= b_rdy;
         vb   <= b_val;
         qb   <= b_tag;
      end else begin
         if (own_bcast) busy <= 1'b0;
         if (grant) sent <= 1'b1;
         if (busy && !ra && cdb_valid && qa == cdb_tag) begin
            ra <= 1'b1;
            va <= cdb_val;
         end
         if (busy && !rb && cdb_valid && qb == cdb_tag) begin
            rb <= 1'b1;
            vb <= cdb_val;
         end
      end
   end

   assign ready = busy && ra && rb && !sent;

   AST_NO_REALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !busy); // R2
   AST_FREE_ON_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      own_bcast |=> !busy); // R7
   AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (busy && ra && rb)); // R6

endmodule

// File: rtl/fpr_fu.sv
module fpr_fu
   import fpr_pkg::*;
#(
   parameter int NRS = 6,
   parameter int DW  = 16,
   parameter int LAT = 3,
   localparam int TW = $clog2(NRS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           disp_valid,
   input  logic [TW-1:0]  disp_tag,
   input  fpr_op_e        disp_op,
   input  logic [DW-1:0]  disp_a,
   input  logic [DW-1:0]  disp_b,
   output logic           res_valid,
   output logic [TW-1:0]  res_tag,
   output logic [DW-1:0]  res_val
);

   logic [DW-1:0] calc;
   logic          pv [LAT];
   logic [TW-1:0] pt [LAT];
   logic [DW-1:0] pd [LAT];

   always_comb begin
      unique case (disp_op)
         OP_ADD:  calc = disp_a + disp_b;
         OP_SUB:  calc = disp_a - disp_b;
         OP_AND:  calc = disp_a & disp_b;
         default: calc = disp_a ^ disp_b;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
      end else begin
         pv[0] <= disp_valid;
         for (int k = 1; k < LAT; k++) pv[k] <= pv[k-1];
      end
   end

   always_ff @(posedge clk) begin
      pt[0] <= disp_tag;
      pd[0] <= calc;
      for (int k = 1; k < LAT; k++) begin
         pt[k] <= pt[k-1];
         pd[k] <= pd[k-1];
      end
   end

   assign res_valid = pv[LAT-1];
   assign res_tag   = pt[LAT-1];
   assign res_val   = pd[LAT-1];

endmodule

// File: rtl/fpr_rename_core.sv
module fpr_rename_core
   import fpr_pkg::*;
#(
   parameter int NREG = 4,
   parameter int NRS  = 6,
   parameter int DW   = 16,
   parameter int LAT  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [1:0]                in_op,
   input  logic [$clog2(NREG)-1:0]   in_dst,
   input  logic [$clog2(NREG)-1:0]   in_src_a,
   input  logic [$clog2(NREG)-1:0]   in_src_b,
   output logic [NREG*DW-1:0]        reg_value,
   output logic [NREG-1:0]           reg_pending,
   output logic                      cdb_valid,
   output logic [$clog2(NRS)-1:0]    cdb_tag,
   output logic [DW-1:0]             cdb_value
);

   localparam int RW = $clog2(NREG);
   localparam int TW = $clog2(NRS);

   if (NREG < 2) begin : g_bad_nreg
      $error("NREG must be at least 2");
   end
   if (NRS <= NREG) begin : g_bad_nrs
      $error("NRS must exceed NREG so stations outnumber registers");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [NRS-1:0] st_busy, st_ready, alloc_vec, grant;
   fpr_op_e        st_op [NRS];
   logic [DW-1:0]  st_va [NRS];
   logic [DW-1:0]  st_vb [NRS];
   logic [TW-1:0]  alloc_tag;
   logic           any_free, fire;

   logic           a_rdy, b_rdy;
   logic [DW-1:0]  a_val, b_val;
   logic [TW-1:0]  a_tag, b_tag;

   logic           disp_valid;
   logic [TW-1:0]  disp_tag;
   fpr_op_e        disp_op;
   logic [DW-1:0]  disp_a, disp_b;

   // lowest-numbered free station
   always_comb begin
      any_free  = 1'b0;
      alloc_tag = '0;
      for (int s = NRS - 1; s >= 0; s--) begin
         if (!st_busy[s]) begin
            any_free  = 1'b1;
            alloc_tag = TW'(s);
         end
      end
   end

   assign in_ready = any_free;
   assign fire     = in_valid && any_free;

   // lowest-numbered ready station wins dispatch
   always_comb begin
      grant = '0;
      for (int s = NRS - 1; s >= 0; s--) begin
         if (st_ready[s]) begin
            grant    = '0;
            grant[s] = 1'b1;
         end
      end
   end

   always_comb begin
      disp_valid = |grant;
      disp_tag   = '0;
      disp_op    = OP_ADD;
      disp_a     = '0;
      disp_b     = '0;
      for (int s = 0; s < NRS; s++) begin
         if (grant[s]) begin
            disp_tag = TW'(s);
            disp_op  = st_op[s];
            disp_a   = st_va[s];
            disp_b   = st_vb[s];
         end
      end
   end

   fpr_regstat #(.NREG(NREG), .NRS(NRS), .DW(DW)) i_regstat (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_fire  (fire),
      .iss_dst   (in_dst),
      .iss_tag   (alloc_tag),
      .src_a     (in_src_a),
      .src_b     (in_src_b),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_val   (cdb_value),
      .a_rdy     (a_rdy),
      .a_val     (a_val),
      .a_tag     (a_tag),
      .b_rdy     (b_rdy),
      .b_val     (b_val),
      .b_tag     (b_tag),
      .reg_flat  (reg_value),
      .pend      (reg_pending)
   );

   for (genvar s = 0; s < NRS; s++) begin : g_rs
      assign alloc_vec[s] = fire && (alloc_tag == TW'(s));

      fpr_station #(.ID(s), .NRS(NRS), .DW(DW)) i_station (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (alloc_vec[s]),
         .alloc_op  (fpr_op_e'(in_op)),
         .a_rdy     (a_rdy),
         .a_val     (a_val),
         .a_tag     (a_tag),
         .b_rdy     (b_rdy),
         .b_val     (b_val),
         .b_tag     (b_tag),
         .cdb_valid (cdb_valid),
         .cdb_tag   (cdb_tag),
         .cdb_val   (cdb_value),
         .grant     (grant[s]),
         .busy      (st_busy[s]),
         .ready     (st_ready[s]),
         .op        (st_op[s]),
         .va        (st_va[s]),
         .vb        (st_vb[s])
      );
   end

   fpr_fu #(.NRS(NRS), .DW(DW), .LAT(LAT)) i_fu (
      .clk        (clk),
      .rst_n      (rst_n),
      .disp_valid (disp_valid),
      .disp_tag   (disp_tag),
      .disp_op    (disp_op),
      .disp_a     (disp_a),
      .disp_b     (disp_b),
      .res_valid  (cdb_valid),
      .res_tag    (cdb_tag),
      .res_val    (cdb_value)
   );

   AST_CDB_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid |-> st_busy[cdb_tag]); // R7
   AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_vec) && (fire -> $countones(alloc_vec) == 1)); // R2

endmodule

// File: tb/test_fpr_rename_core.sv
module test_fpr_rename_core;

   localparam int NREG = 4;
   localparam int NRS  = 6;
   localparam int DW   = 16;
   localparam int LAT  = 3;
   localparam int RW   = $clog2(NREG);
   localparam int TW   = $clog2(NRS);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic [1:0]           in_op = '0;
   logic [RW-1:0]        in_dst = '0, in_src_a = '0, in_src_b = '0;
   logic [NREG*DW-1:0]   reg_value;
   logic [NREG-1:0]      reg_pending;
   logic                 cdb_valid;
   logic [TW-1:0]        cdb_tag;
   logic [DW-1:0]        cdb_value;

   always #5 clk = ~clk;

   fpr_rename_core #(.NREG(NREG), .NRS(NRS), .DW(DW), .LAT(LAT)) i_fpr_rename_core (
      .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_dst, .in_src_a, .in_src_b,
      .reg_value, .reg_pending, .cdb_valid, .cdb_tag, .cdb_value
   );

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int occ = 0;
   int stalls = 0;
   bit mon_en = 1'b0;
   int bc_cnt = 0;
   int bc_tag [8];
   int bc_cyc [8];
   logic [DW-1:0] refm [NREG];
   int unsigned seed = 32'h1234_5678;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] op_eval(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
      case (op)
         2'd0:    return a + b;
         2'd1:    return a - b;
         2'd2:    return a & b;
         default: return a ^ b;
      endcase
   endfunction

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 8;
   endfunction

   // monitor: away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
      if (mon_en) begin
         check(in_ready == (occ < NRS), "R2/R7 in_ready vs occupancy", int'(in_ready), int'(occ < NRS));
         if (in_valid && !in_ready) stalls++;
         if (cdb_valid && bc_cnt < 8) begin
            bc_tag[bc_cnt] = int'(cdb_tag);
            bc_cyc[bc_cnt] = cyc;
            bc_cnt++;
         end
         occ = occ + ((in_valid && in_ready) ? 1 : 0) - (cdb_valid ? 1 : 0);
      end
   end

   task automatic send(input logic [1:0] op, input int d, input int a, input int b);
      bit acc;
      in_valid = 1'b1;
      in_op    = op;
      in_dst   = RW'(d);
      in_src_a = RW'(a);
      in_src_b = RW'(b);
      do begin
         @(negedge clk);
         acc = in_ready;
         @(posedge clk);
         #1;
      end while (!acc);
      in_valid = 1'b0;
      refm[d] = op_eval(op, refm[a], refm[b]);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic drain_and_compare(input string tag);
      while (occ != 0) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check(reg_pending == '0, "R5 no pending after drain", int'(reg_pending), 0);
      for (int r = 0; r < NREG; r++)
         check(reg_value[r*DW +: DW] == refm[r], {"R3/R5 register vs program order ", tag},
               int'(reg_value[r*DW +: DW]), int'(refm[r]));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      mon_en = 1'b0;
      occ = 0;
      idle(3);
      rst_n = 1'b1;
      for (int r = 0; r < NREG; r++) refm[r] = DW'(r + 1);
      mon_en = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1: reset state
      @(negedge clk);
      check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
      check(reg_pending == '0, "R1 pending after reset", int'(reg_pending), 0);
      check(cdb_valid == 1'b0, "R1 bus idle after reset", int'(cdb_valid), 0);
      for (int r = 0; r < NREG; r++)
         check(reg_value[r*DW +: DW] == DW'(r + 1), "R1 register reset value",
               int'(reg_value[r*DW +: DW]), r + 1);
      @(posedge clk);
      #1;

      // R6: two consumers wake together; lowest station goes first
      bc_cnt = 0;
      send(2'd0, 0, 1, 2);   // station 0
      send(2'd1, 2, 0, 0);   // station 1, waits on 0
      send(2'd3, 3, 0, 1);   // station 2, waits on 0
      drain_and_compare("R6 pair");
      check(bc_cnt == 3, "R6 broadcast count", bc_cnt, 3);
      check(bc_tag[0] == 0 && bc_tag[1] == 1 && bc_tag[2] == 2, "R6 broadcast order",
            bc_tag[0] * 100 + bc_tag[1] * 10 + bc_tag[2], 12);
      check(bc_cyc[1] - bc_cyc[0] == LAT + 1, "R6 latency wake to broadcast",
            bc_cyc[1] - bc_cyc[0], LAT + 1);
      check(bc_cyc[2] - bc_cyc[1] == 1, "R6 one dispatch per cycle", bc_cyc[2] - bc_cyc[1], 1);

      // R4: sweep producer-to-consumer gap across the broadcast cycle
      for (int g = 0; g <= LAT + 4; g++) begin
         do_reset();
         send(2'd0, 1, 2, 3);
         idle(g);
         send(2'd1, 0, 1, 2);
         send(2'd3, 3, 1, 0);
         drain_and_compare("R4 gap sweep");
      end

      // R5: old writer finishes after a newer writer of the same register
      do_reset();
      send(2'd0, 0, 1, 1);
      send(2'd0, 0, 0, 0);
      send(2'd0, 0, 0, 0);
      send(2'd3, 0, 2, 3);   // independent, completes before the chain
      drain_and_compare("R5 overwrite");

      // R2/R3/R5: random streams, dependency-heavy, with gaps
      for (int st = 0; st < 40; st++) begin
         do_reset();
         for (int i = 0; i < 30; i++) begin
            int unsigned v;
            v = rnd();
            send(v[1:0], int'(v[3:2]), int'(v[5:4]), int'(v[7:6]));
            if (v[12:10] == 3'd0) idle(int'(v[15:13]));
         end
         drain_and_compare("R3 random stream");
      end

      check(stalls > 0, "R2 full stations stall input", stalls, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule